// File: doc/BRIEF.md
# Six-Channel Lead-In Pulse-Width Modulator

This block holds a bank of pulse-width modulation channels behind a single word-addressed register port. Each channel has two 32-bit words. The control word carries a run bit, a delay before the first pulse, and a limit on the number of periods. The timing word carries the high and low durations, both counted in input clock cycles. Software writes both words. When the run bit is set, the channel holds its output low for the delay, then produces periods of a high phase followed by a low phase.

Each channel is a small state machine with five states:
- `CH_IDLE`: the channel is stopped and its output is low.
- `CH_LEAD`: the channel counts out the initial low delay.
- `CH_HIGH`: the high phase of a period.
- `CH_LOW`: the low phase of a period.
- `CH_DONE`: the period limit has been reached and the output is held low.

The transitions are:
- **start**: `CH_IDLE` goes to `CH_LEAD` when the run bit is set and the delay is nonzero. With a zero delay, it goes straight to a period start.
- **lead_over**: `CH_LEAD` goes to a period start when its counter reaches zero.
- **to_low**: `CH_HIGH` goes to `CH_LOW` when the high count expires and the low time is nonzero.
- **period_end**: a period ends either in `CH_LOW` when its count expires, or in `CH_HIGH` when the high count expires and the low time is zero. The state machine then starts another period, or goes to `CH_DONE` if the limit is met.
- **stop**: any state goes to `CH_IDLE` when the run bit is clear.

A period start loads the current timing word. It enters `CH_HIGH` if the high time is nonzero, and `CH_LOW` otherwise.

Top module: `lead_pwm_bank`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: The word address is 4 bits. Bit 3 selects the timing word (1) or the control word (0), and bits 2:0 select the channel, so byte offsets are 4×word. Every existing register reads back the full 32-bit word last written. Slots 6 and 7 read zero and ignore writes.
- R3: Control word fields are: bit 31 run, bits 30:16 delay D, bits 15:0 period limit N. A write that sets run is sampled at clock edge E0. The output is low after edges E1 through E(D), and the first high phase begins at edge E(1+D).
- R4: Timing word fields are: bits 31:16 high time H, bits 15:0 low time L. Each period is H cycles high followed by L cycles low.
- R5: With N nonzero, the output stays low after N periods, and the run bit still reads 1.
- R6: With N zero, periods repeat without end.
- R7: A timing write during a run leaves the current period unchanged. The new H and L apply from the next period start.
- R8: If a write clearing run is sampled at edge E0, the output is low from edge E1 onward. A later enable restarts from the delay phase using the current timing word.
- R9: With H=0 the output stays low. With L=0 and H nonzero the output stays high. With H=L=0 the output stays low, and each period lasts one cycle.
- R10: Channels are independent. A write to one channel changes neither the registers nor the output of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_word | input | 4 | Word address: bit 3 selects the bank, bits 2:0 select the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_word` |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
- **Register writes:** a write is sampled at one edge and is visible on `bus_rdata` right after it. The bench therefore reads one cycle after the strobe, a nanosecond after it changes the address.
- **Channel response:** a channel reacts to a control or timing change one edge after the register takes it. Cycle j of a run is the output after edge E(j+1).
- **Sampling:** every per-cycle comparison is made at the falling edge following that rising edge. A disable is checked at the first falling edge after E1.
- **Expected waveform:** it is computed from D, N, H and L by a closed-form model of the delay, the period position and the period limit.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
    parameter int WORD_W = 32;
    parameter int CNT_W  = 16;
    parameter int LEAD_W = 15;
    parameter int SLOT_W = 3;
    localparam int RUN_BIT = WORD_W - 1;
    localparam int LEAD_LO = CNT_W;
    localparam int LEAD_HI = CNT_W + LEAD_W - 1;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_LEAD,
        CH_HIGH,
        CH_LOW,
        CH_DONE
    } ch_state_e;
endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
    import lpwm_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [SLOT_W:0]                bus_word,
    input  logic [WORD_W-1:0]              bus_wdata,
    output logic [WORD_W-1:0]              bus_rdata,
    output logic [NUM_CH-1:0][WORD_W-1:0]  ctrl_o,
    output logic [NUM_CH-1:0][WORD_W-1:0]  tim_o
);
    logic [SLOT_W-1:0] slot;
    logic              bank_tim;

    assign slot     = bus_word[SLOT_W-1:0];
    assign bank_tim = bus_word[SLOT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            tim_o  <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (slot == SLOT_W'(i)) begin
                    if (bank_tim) tim_o[i]  <= bus_wdata;
                    else          ctrl_o[i] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot == SLOT_W'(i)) bus_rdata = bank_tim ? tim_o[i] : ctrl_o[i];
        end
    end
endmodule

// File: rtl/lpwm_chan.sv
module lpwm_chan
    import lpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] tim_i,
    output logic              pwm_o
);
    logic              run;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  lim, th, tl;

    assign run  = ctrl_i[RUN_BIT];
    assign lead = ctrl_i[LEAD_HI:LEAD_LO];
    assign lim  = ctrl_i[CNT_W-1:0];
    assign th   = tim_i[WORD_W-1:CNT_W];
    assign tl   = tim_i[CNT_W-1:0];

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, lo_q, lo_d, lim_q, lim_d, per_q, per_d;
    logic             begin_per, end_per;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            lo_q    <= '0;
            lim_q   <= '0;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lo_q    <= lo_d;
            lim_q   <= lim_d;
            per_q   <= per_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        lo_d      = lo_q;
        lim_d     = lim_q;
        per_d     = per_q;
        begin_per = 1'b0;
        end_per   = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (run) begin
                    lim_d = lim;
                    per_d = '0;
                    if (lead != '0) begin
                        state_d = CH_LEAD;
                        cnt_d   = {1'b0, lead} - CNT_W'(1);
                    end else begin
                        begin_per = 1'b1;
                    end
                end
            end
            CH_LEAD: begin
                if (cnt_q == '0) begin_per = 1'b1;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            CH_HIGH: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (lo_q != '0) begin
                    state_d = CH_LOW;
                    cnt_d   = lo_q - CNT_W'(1);
                end else begin
                    end_per = 1'b1;
                end
            end
            CH_LOW: begin
                if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
                else             end_per = 1'b1;
            end
            CH_DONE: ;
        endcase

        if (end_per) begin
            if (lim_q != '0 && per_q + CNT_W'(1) == lim_q) begin
                state_d = CH_DONE;
            end else begin
                per_d     = per_q + CNT_W'(1);
                begin_per = 1'b1;
            end
        end

        if (begin_per) begin
            lo_d = tl;
            if (th != '0) begin
                state_d = CH_HIGH;
                cnt_d   = th - CNT_W'(1);
            end else begin
                state_d = CH_LOW;
                cnt_d   = (tl == '0) ? '0 : tl - CNT_W'(1);
            end
        end

        if (!run) state_d = CH_IDLE;
    end

    always_comb begin
        pwm_o = (state_q == CH_HIGH);
    end
endmodule

// File: rtl/lead_pwm_bank.sv
module lead_pwm_bank
    import lpwm_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [SLOT_W:0]   bus_word,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][WORD_W-1:0] ctrl_w;
    logic [NUM_CH-1:0][WORD_W-1:0] tim_w;

    lpwm_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_o    (ctrl_w),
        .tim_o     (tim_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        lpwm_chan chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ctrl_w[i]),
            .tim_i  (tim_w[i]),
            .pwm_o  (pwm_out[i])
        );
    end
endmodule

// File: rtl/lpwm_chk.sv
module lpwm_chk
    import lpwm_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [SLOT_W:0]               bus_word,
    input logic [WORD_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0][WORD_W-1:0] ctrl_w,
    input logic [NUM_CH-1:0][WORD_W-1:0] tim_w,
    input logic [NUM_CH-1:0]             pwm_out
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R8
        stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_w[i][RUN_BIT] |=> !pwm_out[i]);
        // R4
        rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[i]) |-> $past(ctrl_w[i][RUN_BIT]));
        // R2
        ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word == {1'b0, SLOT_W'(i)}) |=> ctrl_w[i] == $past(bus_wdata));
        // R2
        tim_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word == {1'b1, SLOT_W'(i)}) |=> tim_w[i] == $past(bus_wdata));
        // R10
        other_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word[SLOT_W-1:0] != SLOT_W'(i)) |=> $stable(ctrl_w[i]) && $stable(tim_w[i]));
    end
endmodule

bind lead_pwm_bank lpwm_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .ctrl_w    (ctrl_w),
    .tim_w     (tim_w),
    .pwm_out   (pwm_out)
);

// File: tb/lead_pwm_bank_tb_top.sv
module lead_pwm_bank_tb_top;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    lead_pwm_bank #(.NUM_CH(NCH)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_word (bus_word),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pwm_out (pwm_out)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [14:0] lead;
        logic [15:0] lim;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [7:0]  ncyc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 15'd3, 16'd0, 16'd2, 16'd3, 8'd30},  // R3 R4 R6
        '{3'd1, 15'd0, 16'd2, 16'd3, 16'd1, 8'd20},  // R5
        '{3'd2, 15'd1, 16'd0, 16'd0, 16'd4, 8'd12},  // R9 high zero
        '{3'd3, 15'd2, 16'd0, 16'd4, 16'd0, 8'd12},  // R9 low zero
        '{3'd4, 15'd0, 16'd3, 16'd0, 16'd0, 8'd8},   // R9 both zero
        '{3'd5, 15'd5, 16'd1, 16'd1, 16'd1, 8'd12},  // R5 R3
        '{3'd0, 15'd0, 16'd0, 16'd1, 16'd1, 8'd10}   // R4
    };

    function automatic logic exp_out(int j, int ld, int lm, int h, int l);
        int p;
        int t;
        p = (h + l == 0) ? 1 : h + l;
        if (j < ld) return 1'b0;
        t = j - ld;
        if (lm != 0 && t >= lm * p) return 1'b0;
        return (t % p) < h;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] w, input logic [31:0] exp, input string req);
        bus_word = w;
        #1;
        check(bus_rdata, exp, req);
    endtask

    function automatic logic [31:0] ctl(int lead, int lim);
        return {1'b1, 15'(lead), 16'(lim)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(32'(pwm_out), 32'd0, "R1");
        rd_check(4'h0, 32'd0, "R1");
        rd_check(4'hD, 32'd0, "R1");

        // R2 readback, unused slots
        wr(4'h2, 32'h7FFF_1234);
        wr(4'hA, 32'hDEAD_BEEF);
        wr(4'h6, 32'hFFFF_FFFF);
        wr(4'hF, 32'h1234_5678);
        rd_check(4'h2, 32'h7FFF_1234, "R2");
        rd_check(4'hA, 32'hDEAD_BEEF, "R2");
        rd_check(4'h6, 32'd0, "R2");
        rd_check(4'hF, 32'd0, "R2");
        // R10 neighbours untouched
        rd_check(4'h3, 32'd0, "R10");
        rd_check(4'hB, 32'd0, "R10");
        check(32'(pwm_out), 32'd0, "R10");
        wr(4'h2, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            wr({1'b1, VECS[v].ch}, {VECS[v].hi, VECS[v].lo});
            wr({1'b0, VECS[v].ch}, ctl(int'(VECS[v].lead), int'(VECS[v].lim)));
            for (int j = 0; j < int'(VECS[v].ncyc); j++) begin
                @(negedge clk);
                check(32'(pwm_out[VECS[v].ch]),
                      32'(exp_out(j, int'(VECS[v].lead), int'(VECS[v].lim),
                                  int'(VECS[v].hi), int'(VECS[v].lo))), "R3/R4/R6/R9");
                check(32'(pwm_out & ~(NCH'(1) << VECS[v].ch)), 32'd0, "R10");
            end
            if (VECS[v].lim != 0) begin
                // R5 run bit still set after limit reached
                rd_check({1'b0, VECS[v].ch}, ctl(int'(VECS[v].lead), int'(VECS[v].lim)), "R5");
            end
            wr({1'b0, VECS[v].ch}, 32'd0);
            @(negedge clk);
        end

        // R7 timing change mid-period
        begin
            logic exp7 [10] = '{1, 1, 1, 0, 0, 1, 0, 1, 0, 1};
            wr(4'hA, {16'd3, 16'd2});
            wr(4'h2, ctl(0, 0));
            for (int j = 0; j < 10; j++) begin
                @(negedge clk);
                check(32'(pwm_out[2]), 32'(exp7[j]), "R7");
                if (j == 0) begin
                    bus_wr = 1'b1; bus_word = 4'hA; bus_wdata = {16'd1, 16'd1};
                end else begin
                    bus_wr = 1'b0;
                end
            end
            wr(4'h2, 32'd0);
            @(negedge clk);
        end

        // R8 disable mid-high, then restart
        begin
            wr(4'hB, {16'd10, 16'd2});
            wr(4'h3, ctl(0, 0));
            for (int j = 0; j < 9; j++) begin
                @(negedge clk);
                check(32'(pwm_out[3]), (j <= 3) ? 32'd1 : 32'd0, "R8");
                if (j == 2) begin
                    bus_wr = 1'b1; bus_word = 4'h3; bus_wdata = 32'd0;
                end else begin
                    bus_wr = 1'b0;
                end
            end
            wr(4'hB, {16'd2, 16'd1});
            wr(4'h3, ctl(2, 0));
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                check(32'(pwm_out[3]), 32'(exp_out(j, 2, 0, 2, 1)), "R8");
            end
            wr(4'h3, 32'd0);
            @(negedge clk);
            check(32'(pwm_out), 32'd0, "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule